// File: doc/BRIEF.md
# Power-Mode Multicycle Enable Generator

This block derives single-cycle clock-enable pulses for three logic domains (critical, medium, least critical) from one fast clock. A two-bit run-mode input picks how fast each domain may advance: the critical domain always runs at the full rate, and the other two run at a half rate or at a programmable 1/k rate, depending on the mode. Each domain's logic uses the fast clock and acts only on cycles where its enable is high.

Data moving between two domains is captured only on cycles where both domains are enabled. Because of this, a crossing automatically becomes a multicycle path whose length follows the current mode. For each of the three domain pairs, the block gates a launch-valid input with the two enables to form a capture strobe.

All divide counters share one phase. A new mode or k takes effect only on an alignment cycle, which is a cycle where every counter is at zero. No domain ever sees a shortened period.

Top module: `mcp_enable_gen`

## Requirements
- R1: While `rst_n` is low, all enables and all strobes are 0. On the first cycle after `rst_n` rises, all three enables are 1.
- R2: The critical enable `dom_en[0]` is 1 on every cycle out of reset, in every mode.
- R3: With `mode_sel` = 2'b00 (normal), the medium enable `dom_en[1]` pulses every cycle and the least-critical enable `dom_en[2]` pulses every 2nd cycle.
- R4: With `mode_sel` = 2'b01 (low power), both `dom_en[1]` and `dom_en[2]` pulse every 2nd cycle.
- R5: With `mode_sel` = 2'b10 (ultra low power), `dom_en[1]` pulses every 2nd cycle and `dom_en[2]` pulses every k-th cycle, where k = `div_k` for the values 3 to 7.
- R6: In ultra low power mode, `div_k` = 0 selects k = 8, and `div_k` = 1 or 2 is clamped to k = 3.
- R7: `mode_sel` = 2'b11 behaves as normal mode. `div_k` has no effect outside ultra low power mode.
- R8: The strobe bits map to domain pairs as follows: `xfer_stb[0]` is critical/medium, `xfer_stb[1]` is critical/least, and `xfer_stb[2]` is medium/least. Each bit equals the matching `launch_vld` bit AND both domains' enables.
- R9: A change of `mode_sel` or `div_k` is adopted only on a cycle where all three enables pulse together. The new periods count from that cycle; until then, the old periods continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock of frequency f |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Run mode: 00 normal, 01 low power, 10 ultra low power, 11 treated as normal |
| div_k | input | K_W | Least-critical divisor in ultra low power mode (0 means 8) |
| launch_vld | input | 3 | Per-pair launch valid, in the same bit order as `xfer_stb` |
| dom_en | output | 3 | Enables: bit 0 critical, bit 1 medium, bit 2 least critical |
| xfer_stb | output | 3 | Per-pair capture strobes |

## Verification
If a divide counter holds a wrong value, the phase of its enable shifts. The fault shows at the ports within one period of that domain, at most eight cycles, because pulse gaps and the all-domains-together pulses no longer line up. If the stored divisor set is wrong, or is updated between alignment cycles, a period changes before the alignment cycle. The directed switch test catches this: it moves from a 1/7 rate to normal mode partway through a period. A strobe computed with the wrong pair or wrong gating differs from the bench's AND of enables on the very cycle it occurs.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_LOWPWR = 2'b01,
      MODE_ULTRA  = 2'b10,
      MODE_RSVD   = 2'b11
   } run_mode_e;

   localparam int NUM_DOM  = 3;
   localparam int NUM_PAIR = 3;

   // Pair p joins domains pair_lo(p) and pair_hi(p).
   function automatic int pair_lo(input int p);
      return (p == 2) ? 1 : 0;
   endfunction

   function automatic int pair_hi(input int p);
      return (p == 0) ? 1 : 2;
   endfunction

endpackage

// File: rtl/mcp_div_select.sv
module mcp_div_select
   import mcp_pkg::*;
#(
   parameter int K_W   = 3,
   parameter int CNT_W = 4
) (
   input  logic [1:0]                        mode_sel,
   input  logic [K_W-1:0]                    div_k,
   output logic [NUM_DOM-1:0][CNT_W-1:0]     req_div
);

   localparam logic [CNT_W-1:0] K_TOP  = CNT_W'(1 << K_W);
   localparam logic [CNT_W-1:0] K_LOW  = CNT_W'(3);
   localparam logic [CNT_W-1:0] DIV_1  = CNT_W'(1);
   localparam logic [CNT_W-1:0] DIV_2  = CNT_W'(2);

   if (K_W < 2) begin : g_bad_kw
      $error("K_W must be at least 2");
   end
   if (CNT_W < K_W + 1) begin : g_bad_cw
      $error("CNT_W must hold 2**K_W");
   end

   logic [CNT_W-1:0] k_eff;

   always_comb begin
      if (div_k == '0)
         k_eff = K_TOP;
      else if (CNT_W'(div_k) < K_LOW)
         k_eff = K_LOW;
      else
         k_eff = CNT_W'(div_k);
   end

   always_comb begin
      req_div[0] = DIV_1;
      unique case (run_mode_e'(mode_sel))
         MODE_LOWPWR: begin
            req_div[1] = DIV_2;
            req_div[2] = DIV_2;
         end
         MODE_ULTRA: begin
            req_div[1] = DIV_2;
            req_div[2] = k_eff;
         end
         default: begin
            req_div[1] = DIV_1;
            req_div[2] = DIV_2;
         end
      endcase
   end

endmodule

// File: rtl/mcp_rate_counter.sv
module mcp_rate_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] div_now,
   output logic             at_zero
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_inc >= {1'b0, div_now})
         cnt_q <= '0;
      else
         cnt_q <= cnt_inc[CNT_W-1:0];
   end

   // R9
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < div_now);

   // R4
   slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_now > CNT_W'(1) && at_zero) |=> !at_zero);

endmodule

// File: rtl/mcp_enable_gen.sv
module mcp_enable_gen
   import mcp_pkg::*;
#(
   parameter int K_W   = 3,
   parameter int CNT_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_sel,
   input  logic [K_W-1:0]      div_k,
   input  logic [NUM_PAIR-1:0] launch_vld,
   output logic [NUM_DOM-1:0]  dom_en,
   output logic [NUM_PAIR-1:0] xfer_stb
);

   localparam logic [CNT_W-1:0] K_TOP = CNT_W'(1 << K_W);

   logic [NUM_DOM-1:0][CNT_W-1:0] req_div;
   logic [NUM_DOM-1:0][CNT_W-1:0] act_div_q;
   logic [NUM_DOM-1:0][CNT_W-1:0] eff_div;
   logic [NUM_DOM-1:0]            cnt_zero;
   logic                          aligned;

   mcp_div_select #(.K_W(K_W), .CNT_W(CNT_W)) u_sel (
      .mode_sel (mode_sel),
      .div_k    (div_k),
      .req_div  (req_div)
   );

   assign aligned = &cnt_zero;
   assign eff_div = aligned ? req_div : act_div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div_q[0] <= CNT_W'(1);
         act_div_q[1] <= CNT_W'(1);
         act_div_q[2] <= CNT_W'(2);
      end else if (aligned) begin
         act_div_q <= req_div;
      end
   end

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      mcp_rate_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .div_now (eff_div[d]),
         .at_zero (cnt_zero[d])
      );
      assign dom_en[d] = rst_n & cnt_zero[d];
   end

   for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      localparam int LO = pair_lo(p);
      localparam int HI = pair_hi(p);
      assign xfer_stb[p] = launch_vld[p] & dom_en[LO] & dom_en[HI];

      // R8
      stb_both_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
         xfer_stb[p] |-> (dom_en[LO] && dom_en[HI]));
   end

   // R2
   crit_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dom_en[0]);

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned |=> $stable(act_div_q));

   // R6
   least_div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_div_q[2] >= CNT_W'(2) && act_div_q[2] <= K_TOP);

endmodule

// File: tb/mcp_enable_gen_bench.sv
module mcp_enable_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   // {mode[1:0], k[2:0], med period[3:0], least period[3:0]}
   localparam logic [12:0] VEC [NVEC] = '{
      {2'b00, 3'd5, 4'd1, 4'd2},   // R3
      {2'b01, 3'd5, 4'd2, 4'd2},   // R4
      {2'b10, 3'd3, 4'd2, 4'd3},   // R5
      {2'b10, 3'd4, 4'd2, 4'd4},   // R5
      {2'b10, 3'd5, 4'd2, 4'd5},   // R5
      {2'b10, 3'd6, 4'd2, 4'd6},   // R5
      {2'b10, 3'd7, 4'd2, 4'd7},   // R5
      {2'b10, 3'd0, 4'd2, 4'd8},   // R6
      {2'b10, 3'd1, 4'd2, 4'd3},   // R6
      {2'b10, 3'd2, 4'd2, 4'd3},   // R6
      {2'b11, 3'd6, 4'd1, 4'd2},   // R7
      {2'b00, 3'd0, 4'd1, 4'd2}    // R7
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [2:0] div_k = 3'd3;
   logic [2:0] launch_vld = 3'b000;
   logic [2:0] dom_en;
   logic [2:0] xfer_stb;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcp_enable_gen u_mcp_enable_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_sel   (mode_sel),
      .div_k      (div_k),
      .launch_vld (launch_vld),
      .dom_en     (dom_en),
      .xfer_stb   (xfer_stb)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_stb(input logic [2:0] en, input logic [2:0] lv);
      exp_stb[0] = lv[0] & en[0] & en[1];
      exp_stb[1] = lv[1] & en[0] & en[2];
      exp_stb[2] = lv[2] & en[1] & en[2];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state and first cycle out of reset
      launch_vld = 3'b111;
      repeat (3) @(negedge clk);
      #1;
      check("R1 en in reset", int'(dom_en), 0);
      check("R1 stb in reset", int'(xfer_stb), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 first cycle en", int'(dom_en), 7);
      check("R8 first cycle stb", int'(xfer_stb), 7);

      // Table walk: R2..R8
      for (int v = 0; v < NVEC; v++) begin
         int last_m, last_l, bad_m, bad_l, crit_bad, stb_bad, n_m, n_l;
         int exp_m, exp_l;
         mode_sel = VEC[v][12:11];
         div_k    = VEC[v][10:8];
         exp_m    = int'(VEC[v][7:4]);
         exp_l    = int'(VEC[v][3:0]);
         repeat (20) @(negedge clk);
         last_m = -1; last_l = -1; bad_m = 0; bad_l = 0;
         crit_bad = 0; stb_bad = 0; n_m = 0; n_l = 0;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            launch_vld = 3'(c * 5 + v);
            #1;
            if (!dom_en[0]) crit_bad = 1;
            if (xfer_stb != exp_stb(dom_en, launch_vld)) stb_bad = 1;
            if (dom_en[1]) begin
               if (last_m >= 0 && c - last_m != exp_m && bad_m == 0) bad_m = c - last_m;
               last_m = c; n_m++;
            end
            if (dom_en[2]) begin
               if (last_l >= 0 && c - last_l != exp_l && bad_l == 0) bad_l = c - last_l;
               last_l = c; n_l++;
            end
         end
         if (n_m < 2) bad_m = 99;
         if (n_l < 2) bad_l = 99;
         check("R2 critical every cycle", crit_bad, 0);
         check("R3/R4/R5/R7 medium period", (bad_m != 0) ? bad_m : exp_m, exp_m);
         check("R3/R4/R5/R6/R7 least period", (bad_l != 0) ? bad_l : exp_l, exp_l);
         check("R8 strobe gating", stb_bad, 0);
      end

      // R9: switch from ultra (k=7) to normal partway through a period
      @(negedge clk);
      rst_n = 1'b0;
      mode_sel = 2'b10;
      div_k = 3'd7;
      launch_vld = 3'b000;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R9 start aligned", int'(dom_en), 7);
      for (int c = 1; c <= 16; c++) begin
         @(negedge clk);
         if (c == 3) mode_sel = 2'b00;
         #1;
         if (c == 7)  check("R9 least keeps old period c7", int'(dom_en[2]), 1);
         if (c == 9)  check("R9 least idle c9", int'(dom_en[2]), 0);
         if (c == 12) check("R9 least not yet halved c12", int'(dom_en[2]), 0);
         if (c == 13) check("R9 medium still halved c13", int'(dom_en[1]), 0);
         if (c == 14) check("R9 alignment c14", int'(dom_en), 7);
         if (c == 15) check("R9 medium full rate c15", int'(dom_en[1]), 1);
         if (c == 16) check("R9 least every 2nd c16", int'(dom_en[2]), 1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule